// File: doc/BRIEF.md
# Range-Matching Fully Associative Translation Buffer

This block is a small translation buffer in which every slot can hold any mapping. A slot stores a virtual base, a physical base, the log2 of its page size and a global flag. Each slot sets its own page size, so one buffer can hold 1-byte windows next to multi-megabyte regions. An address hits a slot when it falls inside the window that starts at the virtual base and spans the page size. The translated address is the physical base combined with the address offset inside that window.

Software or a page walker drives one request port. One operation is accepted per cycle: lookup, insert, flush everything, flush only non-global slots, or demap the slot covering an address. Every slot carries an age rank, and the ranks together form a recency order. An insert reuses an empty slot if there is one. Otherwise it replaces the least recently used slot. Lookup hits and inserts move their slot to the front of the order.

Top module: `tlb_range_xlat`

## Requirements
- R1: A lookup of address A hits a valid slot exactly when base <= A and A < base + 2^size_log2. An address one past the end of the window misses, and so does an address one below the base.
- R2: On a hit, rsp_paddr equals the slot's physical base ORed with (A AND (2^size_log2 - 1)).
- R3: An insert while any slot is empty takes an empty slot and leaves every valid mapping in place.
- R4: An insert while all slots are valid overwrites the least recently used slot. The inserted slot becomes the most recently used.
- R5: A lookup hit makes the matching slot the most recently used, which changes the slot chosen by later evictions.
- R6: When several valid slots cover the address, the lookup returns the most recently used of them.
- R7: A lookup miss raises rsp_miss for exactly one cycle with rsp_hit low, and changes neither the contents nor the recency order.
- R8: Flush-all (op 2) makes every slot empty.
- R9: Flush-local (op 3) empties the slots whose global flag is clear and keeps the global slots valid and usable.
- R10: Demap (op 4) empties the slot that covers req_vaddr. The relative recency of the remaining slots stays the same.
- R11: Reset empties every slot and drives rsp_done, rsp_hit, rsp_miss and rsp_paddr to zero.
- R12: A request sampled with req_valid high at clock edge k produces a one-cycle rsp_done pulse after edge k+1. The opcodes are: 0 lookup, 1 insert, 2 flush-all, 3 flush-local, 4 demap. Requests on consecutive cycles each see the state left by the previous request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (see R12) |
| req_vaddr | input | VAW | Lookup/demap address, or virtual base for insert |
| req_pbase | input | PAW | Physical base for insert |
| req_szlog | input | SZW | log2 of page size for insert |
| req_global | input | 1 | Global flag for insert |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | Lookup miss |
| rsp_paddr | output | PAW | Translated address on a hit, zero otherwise |

## Verification
The bench probes both edges of a window: the address just past the end and the address just below the base. A comparator with an off-by-one bound would hit on one of them. It also tests a zero-size (1-byte) window. The bench orders lookups so that an eviction picks a different victim if hits do not promote their slot. A demap followed by further inserts shows whether the demap disturbed the recency of the other slots or failed to free its slot for reuse. Overlapping windows inserted in turn expose a selector that picks by slot index instead of by recency. The bench also checks global slots after a local flush, back-to-back requests that depend on each other, and a reset in the middle of operation.

// File: rtl/tlb_xlat_pkg.sv
package tlb_xlat_pkg;

   typedef enum logic [2:0] {
      OP_LOOKUP      = 3'd0,
      OP_INSERT      = 3'd1,
      OP_FLUSH_ALL   = 3'd2,
      OP_FLUSH_LOCAL = 3'd3,
      OP_DEMAP       = 3'd4
   } tlb_op_e;

endpackage

// File: rtl/tlb_range_cmp.sv
// One slot's window comparator: base <= addr < base + 2^szlog.
module tlb_range_cmp #(
   parameter int VAW = 32,
   parameter int SZW = 5
) (
   input  logic           valid,
   input  logic [VAW-1:0] vbase,
   input  logic [SZW-1:0] szlog,
   input  logic [VAW-1:0] addr,
   output logic           match,
   output logic [VAW-1:0] offset
);
   localparam int EW = VAW + 1;

   logic [VAW-1:0] mask;
   logic [EW-1:0]  limit;
   logic           lo_ok, hi_ok;

   assign mask   = ~({VAW{1'b1}} << szlog);
   assign limit  = {1'b0, vbase} + {1'b0, mask} + EW'(1);
   assign lo_ok  = addr >= vbase;
   assign hi_ok  = {1'b0, addr} < limit;
   assign match  = valid & lo_ok & hi_ok;
   assign offset = addr & mask;
endmodule

// File: rtl/tlb_pick.sv
// Chooses the youngest matching slot, the first empty slot and the oldest valid slot.
module tlb_pick #(
   parameter int ENTRIES = 8,
   parameter int RW      = 3
) (
   input  logic [ENTRIES-1:0] match,
   input  logic [ENTRIES-1:0] valid,
   input  logic [RW-1:0]      rank [ENTRIES],
   output logic               hit_any,
   output logic [RW-1:0]      hit_idx,
   output logic               free_any,
   output logic [RW-1:0]      free_idx,
   output logic [RW-1:0]      lru_idx
);
   logic [RW-1:0] best, worst;
   logic          seen;

   always_comb begin
      hit_any = 1'b0;
      hit_idx = '0;
      best    = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (match[i] && (!hit_any || rank[i] < best)) begin
            hit_any = 1'b1;
            best    = rank[i];
            hit_idx = RW'(i);
         end
      end
   end

   always_comb begin
      free_any = 1'b0;
      free_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!valid[i]) begin
            free_any = 1'b1;
            free_idx = RW'(i);
         end
      end
   end

   always_comb begin
      seen    = 1'b0;
      worst   = '0;
      lru_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (valid[i] && (!seen || rank[i] > worst)) begin
            seen    = 1'b1;
            worst   = rank[i];
            lru_idx = RW'(i);
         end
      end
   end
endmodule

// File: rtl/tlb_age.sv
// Recency ranks: the touched slot becomes 0, slots younger than it age by one.
module tlb_age #(
   parameter int ENTRIES = 8,
   parameter int RW      = 3
) (
   input  logic [RW-1:0] rank_q [ENTRIES],
   input  logic          touch,
   input  logic [RW-1:0] touch_idx,
   output logic [RW-1:0] rank_d [ENTRIES]
);
   logic [RW-1:0] t_rank;
   assign t_rank = rank_q[touch_idx];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      always_comb begin
         if (!touch)
            rank_d[i] = rank_q[i];
         else if (RW'(i) == touch_idx)
            rank_d[i] = '0;
         else if (rank_q[i] < t_rank)
            rank_d[i] = rank_q[i] + RW'(1);
         else
            rank_d[i] = rank_q[i];
      end
   end
endmodule

// File: rtl/tlb_range_xlat.sv
module tlb_range_xlat
   import tlb_xlat_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VAW     = 32,
   parameter int PAW     = 32,
   parameter int SZW     = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   input  logic [2:0]     req_op,
   input  logic [VAW-1:0] req_vaddr,
   input  logic [PAW-1:0] req_pbase,
   input  logic [SZW-1:0] req_szlog,
   input  logic           req_global,
   output logic           rsp_done,
   output logic           rsp_hit,
   output logic           rsp_miss,
   output logic [PAW-1:0] rsp_paddr
);
   localparam int RW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 2) begin : g_chk_entries
      $error("tlb_range_xlat: ENTRIES must be at least 2");
   end
   if ((2 ** SZW) < VAW) begin : g_chk_szw
      $error("tlb_range_xlat: SZW too narrow to express every page size");
   end
   if (VAW < 2 || PAW < 2) begin : g_chk_widths
      $error("tlb_range_xlat: address widths too small");
   end

   // registered request stage
   logic           q_valid;
   logic [2:0]     q_op;
   logic [VAW-1:0] q_vaddr;
   logic [PAW-1:0] q_pbase;
   logic [SZW-1:0] q_szlog;
   logic           q_global;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_valid  <= 1'b0;
         q_op     <= '0;
         q_vaddr  <= '0;
         q_pbase  <= '0;
         q_szlog  <= '0;
         q_global <= 1'b0;
      end else begin
         q_valid <= req_valid;
         if (req_valid) begin
            q_op     <= req_op;
            q_vaddr  <= req_vaddr;
            q_pbase  <= req_pbase;
            q_szlog  <= req_szlog;
            q_global <= req_global;
         end
      end
   end

   // slot storage
   logic [ENTRIES-1:0] valid_q, global_q;
   logic [VAW-1:0]     vbase_q [ENTRIES];
   logic [PAW-1:0]     pbase_q [ENTRIES];
   logic [SZW-1:0]     szlog_q [ENTRIES];
   logic [RW-1:0]      rank_q  [ENTRIES];
   logic [RW-1:0]      rank_d  [ENTRIES];

   logic [ENTRIES-1:0] match;
   logic [VAW-1:0]     offs [ENTRIES];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      tlb_range_cmp #(.VAW(VAW), .SZW(SZW)) i_cmp (
         .valid  (valid_q[i]),
         .vbase  (vbase_q[i]),
         .szlog  (szlog_q[i]),
         .addr   (q_vaddr),
         .match  (match[i]),
         .offset (offs[i])
      );
   end

   logic          hit_any, free_any;
   logic [RW-1:0] hit_idx, free_idx, lru_idx;

   tlb_pick #(.ENTRIES(ENTRIES), .RW(RW)) i_pick (
      .match    (match),
      .valid    (valid_q),
      .rank     (rank_q),
      .hit_any  (hit_any),
      .hit_idx  (hit_idx),
      .free_any (free_any),
      .free_idx (free_idx),
      .lru_idx  (lru_idx)
   );

   logic is_lookup, is_insert, is_flush_all, is_flush_local, is_demap;
   assign is_lookup      = q_valid && (q_op == OP_LOOKUP);
   assign is_insert      = q_valid && (q_op == OP_INSERT);
   assign is_flush_all   = q_valid && (q_op == OP_FLUSH_ALL);
   assign is_flush_local = q_valid && (q_op == OP_FLUSH_LOCAL);
   assign is_demap       = q_valid && (q_op == OP_DEMAP);

   logic [RW-1:0] ins_idx, touch_idx;
   logic          touch;
   assign ins_idx   = free_any ? free_idx : lru_idx;
   assign touch     = is_insert || (is_lookup && hit_any);
   assign touch_idx = is_insert ? ins_idx : hit_idx;

   tlb_age #(.ENTRIES(ENTRIES), .RW(RW)) i_age (
      .rank_q    (rank_q),
      .touch     (touch),
      .touch_idx (touch_idx),
      .rank_d    (rank_d)
   );

   logic [PAW-1:0] hit_pa;
   assign hit_pa = pbase_q[hit_idx] | PAW'(offs[hit_idx]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q  <= '0;
         global_q <= '0;
         for (int i = 0; i < ENTRIES; i++) begin
            rank_q[i]  <= RW'(i);
            vbase_q[i] <= '0;
            pbase_q[i] <= '0;
            szlog_q[i] <= '0;
         end
      end else begin
         for (int i = 0; i < ENTRIES; i++) rank_q[i] <= rank_d[i];
         if (is_insert) begin
            valid_q[ins_idx]  <= 1'b1;
            global_q[ins_idx] <= q_global;
            vbase_q[ins_idx]  <= q_vaddr;
            pbase_q[ins_idx]  <= q_pbase;
            szlog_q[ins_idx]  <= q_szlog;
         end
         if (is_flush_all)          valid_q          <= '0;
         if (is_flush_local)        valid_q          <= valid_q & global_q;
         if (is_demap && hit_any)   valid_q[hit_idx] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_done  <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_miss  <= 1'b0;
         rsp_paddr <= '0;
      end else begin
         rsp_done  <= q_valid;
         rsp_hit   <= is_lookup && hit_any;
         rsp_miss  <= is_lookup && !hit_any;
         rsp_paddr <= (is_lookup && hit_any) ? hit_pa : '0;
      end
   end
endmodule

// File: rtl/tlb_range_xlat_chk.sv
module tlb_range_xlat_chk
   import tlb_xlat_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int RW      = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               q_valid,
   input logic [2:0]         q_op,
   input logic [ENTRIES-1:0] valid_q,
   input logic [ENTRIES-1:0] global_q,
   input logic [RW-1:0]      rank_q [ENTRIES],
   input logic               hit_any,
   input logic [RW-1:0]      ins_idx,
   input logic               rsp_done,
   input logic               rsp_hit,
   input logic               rsp_miss
);
   p_done_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> ##2 rsp_done);

   p_done_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> $past(req_valid, 2));

   p_hit_miss_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_hit && rsp_miss));

   p_result_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_hit || rsp_miss) |-> rsp_done);

   p_miss_keeps_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid && q_op == OP_LOOKUP && !hit_any) |=> valid_q == $past(valid_q));

   p_flush_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid && q_op == OP_FLUSH_ALL) |=> valid_q == '0);

   p_flush_local_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid && q_op == OP_FLUSH_LOCAL) |=> (valid_q & ~global_q) == '0);

   p_keep_global_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid && q_op == OP_FLUSH_LOCAL) |=>
         (valid_q & global_q) == $past(valid_q & global_q));

   p_insert_mru_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid && q_op == OP_INSERT) |=>
         (valid_q[$past(ins_idx)] && rank_q[$past(ins_idx)] == '0));

   p_reset_clear_r11: assert property (@(posedge clk)
      !rst_n |=> valid_q == '0);

   for (genvar v = 0; v < ENTRIES; v++) begin : g_rank
      logic [ENTRIES-1:0] holders;
      for (genvar i = 0; i < ENTRIES; i++) begin : g_h
         assign holders[i] = (rank_q[i] == RW'(v));
      end
      p_rank_unique_r4: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(holders) == 1);
      p_miss_keeps_rank_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (q_valid && q_op == OP_LOOKUP && !hit_any) |=> rank_q[v] == $past(rank_q[v]));
   end
endmodule

bind tlb_range_xlat tlb_range_xlat_chk #(.ENTRIES(ENTRIES), .RW(RW)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .q_valid   (q_valid),
   .q_op      (q_op),
   .valid_q   (valid_q),
   .global_q  (global_q),
   .rank_q    (rank_q),
   .hit_any   (hit_any),
   .ins_idx   (ins_idx),
   .rsp_done  (rsp_done),
   .rsp_hit   (rsp_hit),
   .rsp_miss  (rsp_miss)
);

// File: tb/test_tlb_range_xlat.sv
module test_tlb_range_xlat;
   localparam int N = 4;
   localparam logic [2:0] LK = 3'd0, IN = 3'd1, FA = 3'd2, FL = 3'd3, DM = 3'd4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_op = '0;
   logic [31:0] req_vaddr = '0;
   logic [31:0] req_pbase = '0;
   logic [4:0]  req_szlog = '0;
   logic        req_global = 1'b0;
   logic        rsp_done, rsp_hit, rsp_miss;
   logic [31:0] rsp_paddr;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   tlb_range_xlat #(.ENTRIES(N), .VAW(32), .PAW(32), .SZW(5)) i_tlb_range_xlat (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_vaddr(req_vaddr), .req_pbase(req_pbase), .req_szlog(req_szlog),
      .req_global(req_global), .rsp_done(rsp_done), .rsp_hit(rsp_hit),
      .rsp_miss(rsp_miss), .rsp_paddr(rsp_paddr)
   );

   typedef struct packed {
      logic [2:0]  op;
      logic [31:0] va;
      logic [31:0] pa;
      logic [4:0]  sz;
      logic        g;
      logic        eh;
      logic        em;
      logic [31:0] epa;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 35;
   localparam vec_t VEC [NV] = '{
      '{IN, 32'h0000_1000, 32'h8000_0000, 5'd12, 1'b0, 1'b0, 1'b0, 32'h0, 4'd3},  // A
      '{IN, 32'h2000_0000, 32'h4000_0000, 5'd16, 1'b1, 1'b0, 1'b0, 32'h0, 4'd3},  // B global
      '{IN, 32'h0030_0000, 32'h0100_0000, 5'd20, 1'b0, 1'b0, 1'b0, 32'h0, 4'd3},  // C
      '{LK, 32'h0000_1ABC, 32'h0, 5'd0, 1'b0, 1'b1, 1'b0, 32'h8000_0ABC, 4'd2},   // R2
      '{LK, 32'h0000_2000, 32'h0, 5'd0, 1'b0, 1'b0, 1'b1, 32'h0, 4'd1},           // R1 one past end
      '{LK, 32'h0000_0FFF, 32'h0, 5'd0, 1'b0, 1'b0, 1'b1, 32'h0, 4'd1},           // R1 below base
      '{LK, 32'h2000_FFFF, 32'h0, 5'd0, 1'b0, 1'b1, 1'b0, 32'h4000_FFFF, 4'd1},   // R1 last byte
      '{IN, 32'h0000_5000, 32'h0000_9000, 5'd12, 1'b0, 1'b0, 1'b0, 32'h0, 4'd3},  // D into last free slot (R3)
      '{IN, 32'h0000_6000, 32'h0000_A000, 5'd12, 1'b0, 1'b0, 1'b0, 32'h0, 4'd4},  // E evicts C
      '{LK, 32'h0034_5678, 32'h0, 5'd0, 1'b0, 1'b0, 1'b1, 32'h0, 4'd4},           // R4 C gone
      '{LK, 32'h0000_1004, 32'h0, 5'd0, 1'b0, 1'b1, 1'b0, 32'h8000_0004, 4'd5},   // R5 promote A
      '{IN, 32'h0000_7000, 32'h0000_B000, 5'd12, 1'b0, 1'b0, 1'b0, 32'h0, 4'd5},  // F evicts B
      '{LK, 32'h2000_0000, 32'h0, 5'd0, 1'b0, 1'b0, 1'b1, 32'h0, 4'd5},           // R5 B gone
      '{LK, 32'h0000_1FFF, 32'h0, 5'd0, 1'b0, 1'b1, 1'b0, 32'h8000_0FFF, 4'd5},   // R5 A kept
      '{DM, 32'h0000_6800, 32'h0, 5'd0, 1'b0, 1'b0, 1'b0, 32'h0, 4'd10},          // demap E
      '{LK, 32'h0000_6800, 32'h0, 5'd0, 1'b0, 1'b0, 1'b1, 32'h0, 4'd10},          // R10 E gone
      '{IN, 32'h0000_6000, 32'h0000_C000, 5'd12, 1'b1, 1'b0, 1'b0, 32'h0, 4'd10}, // G global, freed slot
      '{IN, 32'h0000_8000, 32'h0000_D000, 5'd12, 1'b0, 1'b0, 1'b0, 32'h0, 4'd10}, // H evicts D
      '{LK, 32'h0000_5004, 32'h0, 5'd0, 1'b0, 1'b0, 1'b1, 32'h0, 4'd10},          // R10 D was oldest
      '{LK, 32'h0000_7008, 32'h0, 5'd0, 1'b0, 1'b1, 1'b0, 32'h0000_B008, 4'd10},  // R10 F kept
      '{FL, 32'h0, 32'h0, 5'd0, 1'b0, 1'b0, 1'b0, 32'h0, 4'd9},
      '{LK, 32'h0000_6123, 32'h0, 5'd0, 1'b0, 1'b1, 1'b0, 32'h0000_C123, 4'd9},   // R9 global kept
      '{LK, 32'h0000_1000, 32'h0, 5'd0, 1'b0, 1'b0, 1'b1, 32'h0, 4'd9},           // R9 A freed
      '{LK, 32'h0000_8000, 32'h0, 5'd0, 1'b0, 1'b0, 1'b1, 32'h0, 4'd9},           // R9 H freed
      '{FA, 32'h0, 32'h0, 5'd0, 1'b0, 1'b0, 1'b0, 32'h0, 4'd8},
      '{LK, 32'h0000_6123, 32'h0, 5'd0, 1'b0, 1'b0, 1'b1, 32'h0, 4'd8},           // R8 global gone too
      '{IN, 32'h0000_0000, 32'h1000_0000, 5'd16, 1'b0, 1'b0, 1'b0, 32'h0, 4'd6},  // P
      '{IN, 32'h0000_0000, 32'h2000_0000, 5'd12, 1'b0, 1'b0, 1'b0, 32'h0, 4'd6},  // Q overlaps P
      '{LK, 32'h0000_0010, 32'h0, 5'd0, 1'b0, 1'b1, 1'b0, 32'h2000_0010, 4'd6},   // R6 Q youngest
      '{LK, 32'h0000_F000, 32'h0, 5'd0, 1'b0, 1'b1, 1'b0, 32'h1000_F000, 4'd6},   // only P
      '{LK, 32'h0000_0010, 32'h0, 5'd0, 1'b0, 1'b1, 1'b0, 32'h1000_0010, 4'd6},   // R6 P now youngest
      '{IN, 32'h9000_0003, 32'h0000_0055, 5'd0, 1'b0, 1'b0, 1'b0, 32'h0, 4'd1},  // 1-byte window
      '{LK, 32'h9000_0003, 32'h0, 5'd0, 1'b0, 1'b1, 1'b0, 32'h0000_0055, 4'd2},   // R2 zero offset
      '{LK, 32'h9000_0004, 32'h0, 5'd0, 1'b0, 1'b0, 1'b1, 32'h0, 4'd1},           // R1 past 1 byte
      '{LK, 32'h9000_0002, 32'h0, 5'd0, 1'b0, 1'b0, 1'b1, 32'h0, 4'd1}            // R1 below 1 byte
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [2:0] op, input logic [31:0] va, input logic [31:0] pa,
                        input logic [4:0] sz, input logic g);
      req_valid  = 1'b1;
      req_op     = op;
      req_vaddr  = va;
      req_pbase  = pa;
      req_szlog  = sz;
      req_global = g;
   endtask

   // called at a negedge; returns at the negedge where the result is visible
   task automatic issue(input logic [2:0] op, input logic [31:0] va, input logic [31:0] pa,
                        input logic [4:0] sz, input logic g);
      drive(op, va, pa, sz, g);
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #(8 * 100000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: outputs zero after reset
      chk("R11 outputs in reset", {rsp_done, rsp_hit, rsp_miss, rsp_paddr}, 35'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 outputs after reset", {rsp_done, rsp_hit, rsp_miss, rsp_paddr}, 35'h0);
      issue(LK, 32'h0, 32'h0, 5'd0, 1'b0);
      chk("R11 empty after reset", {rsp_done, rsp_hit, rsp_miss}, 3'b101);
      @(negedge clk);
      chk("R7 miss lasts one cycle", {rsp_done, rsp_hit, rsp_miss}, 3'b000);

      for (int k = 0; k < NV; k++) begin
         issue(VEC[k].op, VEC[k].va, VEC[k].pa, VEC[k].sz, VEC[k].g);
         chk($sformatf("vec%0d R%0d flags", k, VEC[k].rq),
             {rsp_done, rsp_hit, rsp_miss}, {1'b1, VEC[k].eh, VEC[k].em});
         if (VEC[k].eh)
            chk($sformatf("vec%0d R%0d paddr", k, VEC[k].rq), rsp_paddr, VEC[k].epa);
      end

      // R12: back-to-back dependent requests
      drive(IN, 32'hA000_0000, 32'h0000_3000, 5'd12, 1'b0);
      @(negedge clk);
      drive(LK, 32'hA000_0010, 32'h0, 5'd0, 1'b0);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R12 insert done pulse", {rsp_done, rsp_hit, rsp_miss}, 3'b100);
      @(negedge clk);
      chk("R12 following lookup flags", {rsp_done, rsp_hit, rsp_miss}, 3'b110);
      chk("R12 following lookup paddr", rsp_paddr, 32'h0000_3010);
      @(negedge clk);
      chk("R12 done is one cycle", {rsp_done, rsp_hit, rsp_miss, rsp_paddr}, 35'h0);

      // R11: reset in mid-run empties the buffer
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      issue(LK, 32'hA000_0010, 32'h0, 5'd0, 1'b0);
      chk("R11 reset clears slots", {rsp_done, rsp_hit, rsp_miss}, 3'b101);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule